// File: doc/BRIEF.md
# Timestamp Event Queue

This block collects timestamped events from several sources and keeps them in order of arrival until software takes them. The sources are a software push strobe, a parameterised set of hardware input edges (eight by default) and Ethernet receive and transmit notifications. Receive and transmit notifications already carry their message type, sequence id, domain and port. Each accepted event is stamped with the 64-bit time value on `timeNow` in the cycle the request is sampled. The event then waits in a per-source holding slot until the arbiter writes it into a 16-entry queue.

Software sees the oldest entry as four 32-bit words. It removes that entry by writing a word with bit 0 set to the pop input. A raw pending flag shows that the queue is not empty. The interrupt output is that flag gated by an enable. When the queue is full, newly arbitrated events are discarded and a sticky overflow flag is raised. The flag stays set until reset.

When several sources request in the same cycle, all of the requests are kept. They enter the queue one per clock in fixed priority order, and each keeps the timestamp of its own request cycle. If a source requests again while its earlier event still waits in its holding slot, the second request is ignored.

Top module: `ts_event_queue`

## Requirements
- R1: The queue holds up to 16 entries, and the head words always show the oldest entry still held (first in, first out).
- R2: Word 0 reads timestamp bits 31:0 and word 3 reads timestamp bits 63:32. Word 2 reads the domain in bits 7:0 with zeros above. All four words read zero while the queue is empty.
- R3: Word 1 reads the sequence id in bits 15:0, the message type in bits 19:16, the event type code in bits 23:20 and the port number in bits 28:24, with bits 31:29 zero.
- R4: Event type codes are 0 for a software push, 3 for a hardware input, 4 for Ethernet receive and 5 for Ethernet transmit. Push and hardware-input entries report message type, sequence id and domain as zero, and a push reports port 0.
- R5: Hardware input i (counting from 0) is recorded only while `ctrlWord` bit 8+i is 1, and its entry reports port number i+1.
- R6: A receive notification is recorded only while `ctrlWord` bit 3 is 1. A transmit notification is always recorded with the fields given on its inputs.
- R7: `rawPending` is 1 exactly while the queue holds at least one entry, and `irqOut` equals `rawPending` AND `irqEnable`.
- R8: A write on `popWrite` with `popWord` bit 0 set removes the head entry. A write with bit 0 clear, or a pop while the queue is empty, changes nothing.
- R9: Requests from several sources in one cycle all enter the queue, one per clock. The order is the software push first, then hardware inputs from the lowest index up, then receive, then transmit. Every entry keeps the `timeNow` value of its request cycle.
- R10: An event arbitrated while the queue holds 16 entries is discarded, the queue content is unchanged, and `overflowFlag` becomes 1 and stays 1 until reset.
- R11: A lone request sampled at clock edge E is readable at the head, with `rawPending` set, after edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 64 | Current time value sampled for each request |
| ctrlWord | input | 32 | Control: bit 3 receive enable, bits 8+i hardware input i enable |
| irqEnable | input | 1 | Interrupt enable for the pending status |
| swPush | input | 1 | Software push request (one-cycle pulse) |
| hwEdge | input | NUM_HW | Hardware input event pulses |
| rxValid | input | 1 | Ethernet receive notification |
| rxMsgType | input | 4 | Receive message type |
| rxSeqId | input | 16 | Receive sequence id |
| rxDomain | input | 8 | Receive domain |
| rxPort | input | 5 | Receive port number |
| txValid | input | 1 | Ethernet transmit notification |
| txMsgType | input | 4 | Transmit message type |
| txSeqId | input | 16 | Transmit sequence id |
| txDomain | input | 8 | Transmit domain |
| txPort | input | 5 | Transmit port number |
| popWrite | input | 1 | Write strobe of the pop register |
| popWord | input | 32 | Data of the pop write; bit 0 requests a pop |
| evWord0 | output | 32 | Head timestamp bits 31:0 |
| evWord1 | output | 32 | Head type word |
| evWord2 | output | 32 | Head domain word |
| evWord3 | output | 32 | Head timestamp bits 63:32 |
| rawPending | output | 1 | Queue not empty |
| irqOut | output | 1 | Masked pending status |
| overflowFlag | output | 1 | Sticky flag for a discarded event |

## Verification
The embedded assertions check every cycle that the occupancy never passes 16, that a full queue without a pop keeps its count, that a pop on an empty queue leaves it empty, that a pop lowers the count by one, that the highest-priority waiting source is always served on the next cycle, and that the overflow flag never clears. Only the bench's scenarios can show the remaining behaviour. This covers the packing of the four words and the type codes, and the port numbering and gating of each hardware input. It also covers receive gating, the arrival order and shared timestamp of simultaneous requests, and the exact latency from request to head. Finally, the bench drains a full queue entry by entry after an overflow.

// File: rtl/ts_evq_pkg.sv
package ts_evq_pkg;

  localparam int TYPE_W  = 4;
  localparam int PORT_W  = 5;
  localparam int MSG_W   = 4;
  localparam int SEQ_W   = 16;
  localparam int DOM_W   = 8;
  localparam int STAMP_W = 64;
  // source index width; supports up to 16 sources (NUM_HW <= 13)
  localparam int SEL_W   = 4;

  typedef enum logic [TYPE_W-1:0] {
    EV_PUSH     = 4'd0,
    EV_ROLL     = 4'd1,
    EV_HALFROLL = 4'd2,
    EV_HWIN     = 4'd3,
    EV_ETH_RX   = 4'd4,
    EV_ETH_TX   = 4'd5,
    EV_COMPARE  = 4'd6,
    EV_HOST_TX  = 4'd7
  } evType_e;

  typedef struct packed {
    logic [TYPE_W-1:0]  evType;
    logic [PORT_W-1:0]  port;
    logic [MSG_W-1:0]   msgType;
    logic [SEQ_W-1:0]   seqId;
    logic [DOM_W-1:0]   domain;
    logic [STAMP_W-1:0] stamp;
  } evEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrEn;
    logic             popEn;
    logic [SEL_W-1:0] grantSel;
  } evqStrobe_t;

  function automatic logic [31:0] packTypeWord(evEntry_t e);
    return {3'b000, e.port, e.evType, e.msgType, e.seqId};
  endfunction

endpackage

// File: rtl/ts_evq_ctrl.sv
module ts_evq_ctrl
  import ts_evq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NUM_HW = 8,
  localparam int NSRC  = NUM_HW + 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swPush,
  input  logic [NUM_HW-1:0] hwEdge,
  input  logic [NUM_HW-1:0] hwEnable,
  input  logic              rxValid,
  input  logic              rxEnable,
  input  logic              txValid,
  input  logic              popReq,
  output logic [NSRC-1:0]   loadMask,
  output evqStrobe_t        strobe,
  output logic              notEmpty,
  output logic              overflowFlag
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [NSRC-1:0]  SRC_ONE  = NSRC'(1);

  logic [NSRC-1:0]  srcReq;
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  grantOh;
  logic [SEL_W-1:0] grantSel;
  logic [CNT_W-1:0] cnt;
  logic             anyPend;
  logic             full;
  logic             wrEn;
  logic             popEn;

  // index 0 software push, 1..NUM_HW hardware inputs, then receive, then transmit
  assign srcReq  = {txValid, rxValid & rxEnable, hwEdge & hwEnable, swPush};
  assign anyPend = |pend;
  assign grantOh = pend & (~pend + SRC_ONE);
  assign full    = (cnt == CNT_FULL);
  assign wrEn    = anyPend && !full;
  assign popEn   = popReq && (cnt != '0);

  always_comb begin
    grantSel = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (pend[s]) grantSel = SEL_W'(s);
    end
  end

  // a source may load its holding slot when free or being served this cycle
  assign loadMask = srcReq & (~pend | grantOh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
    end else begin
      pend <= (pend & ~grantOh) | loadMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else begin
      case ({wrEn, popEn})
        2'b10:   cnt <= cnt + CNT_ONE;
        2'b01:   cnt <= cnt - CNT_ONE;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflowFlag <= 1'b0;
    end else if (anyPend && full) begin
      overflowFlag <= 1'b1;
    end
  end

  assign notEmpty        = (cnt != '0);
  assign strobe.wrEn     = wrEn;
  assign strobe.popEn    = popEn;
  assign strobe.grantSel = grantSel;

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_FULL);

  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && !popReq) |=> (cnt == CNT_FULL));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && popReq && !anyPend) |=> (cnt == '0));

  // R8
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && popReq && !anyPend) |=> (cnt == $past(cnt) - CNT_ONE));

  // R9
  prio_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    pend[0] |=> (!pend[0] || $past(srcReq[0])));

endmodule

// File: rtl/ts_evq_data.sv
module ts_evq_data
  import ts_evq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NUM_HW = 8,
  localparam int NSRC  = NUM_HW + 3,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STAMP_W-1:0] timeNow,
  input  logic [MSG_W-1:0]   rxMsgType,
  input  logic [SEQ_W-1:0]   rxSeqId,
  input  logic [DOM_W-1:0]   rxDomain,
  input  logic [PORT_W-1:0]  rxPort,
  input  logic [MSG_W-1:0]   txMsgType,
  input  logic [SEQ_W-1:0]   txSeqId,
  input  logic [DOM_W-1:0]   txDomain,
  input  logic [PORT_W-1:0]  txPort,
  input  logic [NSRC-1:0]    loadMask,
  input  evqStrobe_t         strobe,
  input  logic               headValid,
  output logic [31:0]        evWord0,
  output logic [31:0]        evWord1,
  output logic [31:0]        evWord2,
  output logic [31:0]        evWord3
);

  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
  localparam int RX_IDX = NUM_HW + 1;
  localparam int TX_IDX = NUM_HW + 2;

  evEntry_t         slot [NSRC];
  evEntry_t         newEntry [NSRC];
  evEntry_t         mem [DEPTH];
  evEntry_t         head;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  // per-source entry builders
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (s == 0) begin : g_push
      assign newEntry[s] = '{evType: EV_PUSH, port: '0, msgType: '0,
                             seqId: '0, domain: '0, stamp: timeNow};
    end else if (s <= NUM_HW) begin : g_hw
      assign newEntry[s] = '{evType: EV_HWIN, port: PORT_W'(s), msgType: '0,
                             seqId: '0, domain: '0, stamp: timeNow};
    end else if (s == RX_IDX) begin : g_rx
      assign newEntry[s] = '{evType: EV_ETH_RX, port: rxPort, msgType: rxMsgType,
                             seqId: rxSeqId, domain: rxDomain, stamp: timeNow};
    end else begin : g_tx
      assign newEntry[s] = '{evType: EV_ETH_TX, port: txPort, msgType: txMsgType,
                             seqId: txSeqId, domain: txDomain, stamp: timeNow};
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slot[s] <= '0;
      end else if (loadMask[s]) begin
        slot[s] <= newEntry[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      mem[wrPtr] <= slot[strobe.grantSel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrEn)  wrPtr <= wrPtr + PTR_ONE;
      if (strobe.popEn) rdPtr <= rdPtr + PTR_ONE;
    end
  end

  always_comb begin
    head = headValid ? mem[rdPtr] : '0;
    evWord0 = head.stamp[31:0];
    evWord1 = packTypeWord(head);
    evWord2 = {{(32-DOM_W){1'b0}}, head.domain};
    evWord3 = head.stamp[63:32];
  end

  // R9
  sel_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (int'(strobe.grantSel) < NSRC));

  // R1
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrEn && !strobe.popEn) |=> (wrPtr == $past(wrPtr) && rdPtr == $past(rdPtr)));

  // sanity on TX_IDX derivation
  initial begin
    idx_layout_chk: assert (TX_IDX == NSRC - 1);
  end

endmodule

// File: rtl/ts_event_queue.sv
module ts_event_queue
  import ts_evq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NUM_HW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       timeNow,
  input  logic [31:0]       ctrlWord,
  input  logic              irqEnable,
  input  logic              swPush,
  input  logic [NUM_HW-1:0] hwEdge,
  input  logic              rxValid,
  input  logic [3:0]        rxMsgType,
  input  logic [15:0]       rxSeqId,
  input  logic [7:0]        rxDomain,
  input  logic [4:0]        rxPort,
  input  logic              txValid,
  input  logic [3:0]        txMsgType,
  input  logic [15:0]       txSeqId,
  input  logic [7:0]        txDomain,
  input  logic [4:0]        txPort,
  input  logic              popWrite,
  input  logic [31:0]       popWord,
  output logic [31:0]       evWord0,
  output logic [31:0]       evWord1,
  output logic [31:0]       evWord2,
  output logic [31:0]       evWord3,
  output logic              rawPending,
  output logic              irqOut,
  output logic              overflowFlag
);

  localparam int NSRC      = NUM_HW + 3;
  localparam int RX_EN_BIT = 3;
  localparam int HW_EN_LSB = 8;

  logic [NSRC-1:0]   loadMask;
  evqStrobe_t        strobe;
  logic              notEmpty;
  logic [NUM_HW-1:0] hwEnable;
  logic              rxEnable;
  logic              popReq;
  logic              unusedBits;

  assign hwEnable   = ctrlWord[HW_EN_LSB +: NUM_HW];
  assign rxEnable   = ctrlWord[RX_EN_BIT];
  assign popReq     = popWrite && popWord[0];
  assign unusedBits = ^{ctrlWord[31:HW_EN_LSB+NUM_HW], ctrlWord[7:4],
                        ctrlWord[2:0], popWord[31:1]};

  ts_evq_ctrl #(.DEPTH(DEPTH), .NUM_HW(NUM_HW)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .swPush       (swPush),
    .hwEdge       (hwEdge),
    .hwEnable     (hwEnable),
    .rxValid      (rxValid),
    .rxEnable     (rxEnable),
    .txValid      (txValid),
    .popReq       (popReq),
    .loadMask     (loadMask),
    .strobe       (strobe),
    .notEmpty     (notEmpty),
    .overflowFlag (overflowFlag)
  );

  ts_evq_data #(.DEPTH(DEPTH), .NUM_HW(NUM_HW)) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .timeNow   (timeNow),
    .rxMsgType (rxMsgType),
    .rxSeqId   (rxSeqId),
    .rxDomain  (rxDomain),
    .rxPort    (rxPort),
    .txMsgType (txMsgType),
    .txSeqId   (txSeqId),
    .txDomain  (txDomain),
    .txPort    (txPort),
    .loadMask  (loadMask),
    .strobe    (strobe),
    .headValid (notEmpty),
    .evWord0   (evWord0),
    .evWord1   (evWord1),
    .evWord2   (evWord2),
    .evWord3   (evWord3)
  );

  assign rawPending = notEmpty;
  assign irqOut     = notEmpty && irqEnable;

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEnable || !rawPending) |-> !irqOut);

endmodule

// File: tb/ts_event_queue_tb_top.sv
module ts_event_queue_tb_top;

  localparam int NUM_HW = 8;
  localparam int DEPTH  = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] timeNow = '0;
  logic [31:0] ctrlWord = '0;
  logic        irqEnable = 1'b0;
  logic        swPush = 1'b0;
  logic [NUM_HW-1:0] hwEdge = '0;
  logic        rxValid = 1'b0;
  logic [3:0]  rxMsgType = '0;
  logic [15:0] rxSeqId = '0;
  logic [7:0]  rxDomain = '0;
  logic [4:0]  rxPort = '0;
  logic        txValid = 1'b0;
  logic [3:0]  txMsgType = '0;
  logic [15:0] txSeqId = '0;
  logic [7:0]  txDomain = '0;
  logic [4:0]  txPort = '0;
  logic        popWrite = 1'b0;
  logic [31:0] popWord = '0;
  logic [31:0] evWord0, evWord1, evWord2, evWord3;
  logic        rawPending, irqOut, overflowFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ts_event_queue #(.DEPTH(DEPTH), .NUM_HW(NUM_HW)) dut_i (.*);

  function automatic logic [31:0] typeWord(int port, int ty, int msg, int seq);
    return {3'b000, port[4:0], ty[3:0], msg[3:0], seq[15:0]};
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkHead(string tag, logic [63:0] st, logic [31:0] tw, logic [7:0] dom);
    check32({tag, " word0"}, evWord0, st[31:0]);
    check32({tag, " word1"}, evWord1, tw);
    check32({tag, " word2"}, evWord2, {24'd0, dom});
    check32({tag, " word3"}, evWord3, st[63:32]);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic firePush(logic [63:0] t);
    @(negedge clk);
    timeNow = t; swPush = 1'b1;
    @(negedge clk);
    swPush = 1'b0;
  endtask

  task automatic fireHw(int i, logic [63:0] t);
    @(negedge clk);
    timeNow = t; hwEdge = '0; hwEdge[i] = 1'b1;
    @(negedge clk);
    hwEdge = '0;
  endtask

  task automatic doPop(logic [31:0] w);
    @(negedge clk);
    popWrite = 1'b1; popWord = w;
    @(negedge clk);
    popWrite = 1'b0; popWord = '0;
  endtask

  initial begin
    doReset();
    // reset state R7 R2
    check32("R7 reset raw", {31'd0, rawPending}, 32'd0);
    check32("R7 reset irq", {31'd0, irqOut}, 32'd0);
    check32("R10 reset ovf", {31'd0, overflowFlag}, 32'd0);
    checkHead("R2 empty", 64'd0, 32'd0, 8'd0);

    // latency and push packing: R11 R4
    @(negedge clk);
    timeNow = 64'h1234_5678_9ABC_DEF0; swPush = 1'b1;
    @(negedge clk);  // edge E sampled the request
    swPush = 1'b0;
    check32("R11 not yet visible", {31'd0, rawPending}, 32'd0);
    @(negedge clk);  // after E+1
    check32("R11 visible", {31'd0, rawPending}, 32'd1);
    checkHead("R4 push", 64'h1234_5678_9ABC_DEF0, typeWord(0, 0, 0, 0), 8'd0);

    // interrupt masking R7
    irqEnable = 1'b0; #1;
    check32("R7 irq masked", {31'd0, irqOut}, 32'd0);
    irqEnable = 1'b1; #1;
    check32("R7 irq enabled", {31'd0, irqOut}, 32'd1);

    // pop write with bit0 clear: R8
    doPop(32'hFFFF_FFFE);
    check32("R8 nopop raw", {31'd0, rawPending}, 32'd1);
    checkHead("R8 nopop head", 64'h1234_5678_9ABC_DEF0, typeWord(0, 0, 0, 0), 8'd0);
    doPop(32'h1);
    check32("R8 popped raw", {31'd0, rawPending}, 32'd0);
    check32("R7 irq empty", {31'd0, irqOut}, 32'd0);
    // pop on empty R8
    doPop(32'h1);
    check32("R8 empty pop raw", {31'd0, rawPending}, 32'd0);
    check32("R8 empty pop ovf", {31'd0, overflowFlag}, 32'd0);
    firePush(64'd77);
    @(negedge clk);
    checkHead("R8 after empty pop", 64'd77, typeWord(0, 0, 0, 0), 8'd0);
    doPop(32'h1);

    // hardware inputs enabled sweep R5
    ctrlWord = 32'h0000_FF00;
    for (int i = 0; i < NUM_HW; i++) begin
      fireHw(i, 64'hA000_0000_0000_0000 + 64'(i));
      @(negedge clk);
      checkHead($sformatf("R5 hw%0d", i), 64'hA000_0000_0000_0000 + 64'(i),
                typeWord(i + 1, 3, 0, 0), 8'd0);
      doPop(32'h1);
    end
    // each input disabled alone R5
    for (int i = 0; i < NUM_HW; i++) begin
      ctrlWord = 32'h0000_FF00 & ~(32'h100 << i);
      fireHw(i, 64'd5);
      @(negedge clk);
      @(negedge clk);
      check32($sformatf("R5 hw%0d disabled", i), {31'd0, rawPending}, 32'd0);
    end

    // receive gating R6
    ctrlWord = 32'h0;
    @(negedge clk);
    timeNow = 64'd900; rxValid = 1'b1; rxMsgType = 4'h2; rxSeqId = 16'hBEEF;
    rxDomain = 8'h5A; rxPort = 5'd3;
    @(negedge clk);
    rxValid = 1'b0;
    @(negedge clk); @(negedge clk);
    check32("R6 rx disabled", {31'd0, rawPending}, 32'd0);
    ctrlWord = 32'h0000_0008;
    @(negedge clk);
    timeNow = 64'hFFFF_0000_0000_0901; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
    @(negedge clk);
    checkHead("R6 R3 rx", 64'hFFFF_0000_0000_0901, typeWord(3, 4, 2, 16'hBEEF), 8'h5A);
    doPop(32'h1);
    // transmit, all fields at extremes R3 R6
    ctrlWord = 32'h0;
    @(negedge clk);
    timeNow = 64'h0000_0001_FFFF_FFFF; txValid = 1'b1; txMsgType = 4'hF;
    txSeqId = 16'hFFFF; txDomain = 8'hFF; txPort = 5'd31;
    @(negedge clk);
    txValid = 1'b0;
    @(negedge clk);
    checkHead("R3 tx", 64'h0000_0001_FFFF_FFFF, typeWord(31, 5, 15, 16'hFFFF), 8'hFF);
    doPop(32'h1);

    // simultaneous requests R9
    ctrlWord = 32'h0000_FF08;
    @(negedge clk);
    timeNow = 64'hC0DE_0000_0000_0042;
    swPush = 1'b1; hwEdge = '1; rxValid = 1'b1; txValid = 1'b1;
    rxMsgType = 4'h1; rxSeqId = 16'h0011; rxDomain = 8'h01; rxPort = 5'd1;
    txMsgType = 4'h3; txSeqId = 16'h0033; txDomain = 8'h03; txPort = 5'd2;
    @(negedge clk);
    swPush = 1'b0; hwEdge = '0; rxValid = 1'b0; txValid = 1'b0;
    timeNow = 64'd0;
    repeat (NUM_HW + 3) @(negedge clk);
    checkHead("R9 order push", 64'hC0DE_0000_0000_0042, typeWord(0, 0, 0, 0), 8'd0);
    doPop(32'h1);
    for (int i = 0; i < NUM_HW; i++) begin
      checkHead($sformatf("R9 order hw%0d", i), 64'hC0DE_0000_0000_0042,
                typeWord(i + 1, 3, 0, 0), 8'd0);
      doPop(32'h1);
    end
    checkHead("R9 order rx", 64'hC0DE_0000_0000_0042, typeWord(1, 4, 1, 16'h0011), 8'h01);
    doPop(32'h1);
    checkHead("R9 order tx", 64'hC0DE_0000_0000_0042, typeWord(2, 5, 3, 16'h0033), 8'h03);
    doPop(32'h1);
    check32("R9 drained", {31'd0, rawPending}, 32'd0);

    // fill and overflow R1 R10
    for (int k = 0; k < DEPTH; k++) firePush(64'(1000 + k));
    @(negedge clk);
    check32("R10 full no ovf", {31'd0, overflowFlag}, 32'd0);
    firePush(64'd9999);
    @(negedge clk);
    check32("R10 ovf set", {31'd0, overflowFlag}, 32'd1);
    for (int k = 0; k < DEPTH; k++) begin
      checkHead($sformatf("R1 fifo %0d", k), 64'(1000 + k), typeWord(0, 0, 0, 0), 8'd0);
      doPop(32'h1);
    end
    check32("R1 empty after 16", {31'd0, rawPending}, 32'd0);
    check32("R10 ovf sticky", {31'd0, overflowFlag}, 32'd1);
    doReset();
    check32("R10 ovf reset", {31'd0, overflowFlag}, 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule